// File: doc/BRIEF.md
# FIFO Read Port with Selectable Output Width

This block is the read side of a frame-buffer FIFO. It keeps a read pointer into a synchronous memory array that sits outside it, sends read requests to that array, and puts each returned word into a registered 12-bit output. An active-low read enable chooses which words are fetched. An active-low output enable, together with a width-mode selection, decides which output bits are driven.

The read enable is sampled one edge before it takes effect. When it is sampled low, the next cycle issues a memory read at the current pointer and advances the pointer. The word comes back one cycle later and is loaded into the output register. When the read enable is sampled high, the pointer and the output register both stay as they are. Tri-state is modelled by a data vector plus a per-bit enable vector. Bits that the selected width leaves out are never enabled. They are always presented as zero, and the stored register value is not changed.

A synchronous active-low reset clears the pointer, the read pipeline and the output register. It holds all of them at zero for as long as it stays low.

Top module: `fifo_rd_port`

## Requirements
- R1: While rst_ni is low at a rising edge, ptr_o and the output register are forced to 0 after that edge, whatever ren_ni is, and no read is issued.
- R2: When ren_ni is sampled low at edge k, mem_req_o is high with mem_addr_o equal to ptr_o during the following cycle, and ptr_o advances by one at edge k+1.
- R3: The memory returns the word one cycle after a request. The word read at address p is loaded into the output register at edge k+2, where k is the edge at which ren_ni was sampled low and p is ptr_o before edge k+1.
- R4: When ren_ni is sampled high at edge k, ptr_o does not change at edge k+1 and the output register does not change at edge k+2.
- R5: ptr_o wraps from DEPTH-1 to 0 on an advance.
- R6: While oe_ni is high, every bit of oe_o is 0.
- R7: mode_i = 2'b00 selects 12-bit width. With oe_ni low, oe_o = 12'hFFF and q_o equals the whole output register.
- R8: mode_i = 2'b01 selects 10-bit width. oe_o[1:0] and q_o[1:0] are 0, and bits 11:2 follow R6/R7.
- R9: mode_i = 2'b10 or 2'b11 selects 8-bit width. oe_o[3:0] and q_o[3:0] are 0, and bits 11:4 follow R6/R7.
- R10: oe_ni has no effect on ptr_o or on the contents of the output register.
- R11: The width mode only masks the output. After a switch back to 12-bit mode, the full stored word reappears on q_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| ren_ni | input | 1 | Read enable, active low, sampled one cycle ahead |
| oe_ni | input | 1 | Output enable, active low |
| mode_i | input | 2 | Width mode: 00 = 12-bit, 01 = 10-bit, 1x = 8-bit |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after the request |
| q_o | output | DATA_W | Registered data, with inactive bits forced to 0 |
| oe_o | output | DATA_W | Per-bit drive enable |
| ptr_o | output | ADDR_W | Current read pointer |

## Verification
The bench runs with a memory depth of 12, so the pointer wraps at a boundary that is not a power of two. A counter that wraps at a power of two would show 12 instead of 0. Single-cycle read and skip pulses test the two-edge alignment: a design with one pipeline stage too few or too many loads the neighbouring word and fails on every pulse. Changing the width mode or toggling the output enable while a word is held shows whether the mask is wrongly written into the register. In that case the low bits stay zero after the return to 12-bit mode. A reset asserted mid-stream with the read enable held low shows whether the pipeline keeps advancing during reset.

// File: rtl/fifo_rd_pkg.sv
package fifo_rd_pkg;
  typedef enum logic [1:0] {
    WM_12  = 2'b00,
    WM_10  = 2'b01,
    WM_8   = 2'b10,
    WM_8_B = 2'b11
  } width_mode_e;

  localparam int unsigned DROP_10 = 2;
  localparam int unsigned DROP_8  = 4;

  function automatic int unsigned drop_bits(width_mode_e m);
    case (m)
      WM_12:   return 0;
      WM_10:   return DROP_10;
      default: return DROP_8;
    endcase
  endfunction
endpackage

// File: rtl/fifo_rd_ptr.sv
module fifo_rd_ptr #(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/fifo_rd_pipe.sv
module fifo_rd_pipe #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ren_ni,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fire_o,
  output logic [DATA_W-1:0] q_o
);
  // stage 1: sampled enable, stage 2: data in flight from memory
  logic              fire_q;
  logic              fetch_q;
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      fire_q  <= 1'b0;
      fetch_q <= 1'b0;
      q_q     <= '0;
    end else begin
      fire_q  <= ~ren_ni;
      fetch_q <= fire_q;
      if (fetch_q) q_q <= rdata_i;
    end
  end

  assign fire_o = fire_q;
  assign q_o    = q_q;
endmodule

// File: rtl/fifo_rd_mask.sv
module fifo_rd_mask
  import fifo_rd_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  width_mode_e       mode_i,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] q_i,
  output logic [DATA_W-1:0] q_o,
  output logic [DATA_W-1:0] oe_o
);
  int unsigned drop;
  assign drop = drop_bits(mode_i);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic active;
    assign active  = (i >= drop);
    assign q_o[i]  = active & q_i[i];
    assign oe_o[i] = active & ~oe_ni;
  end
endmodule

// File: rtl/fifo_rd_port.sv
module fifo_rd_port
  import fifo_rd_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ren_ni,
  input  logic              oe_ni,
  input  logic [1:0]        mode_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] q_o,
  output logic [DATA_W-1:0] oe_o,
  output logic [ADDR_W-1:0] ptr_o
);
  logic              fire;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] q_reg;

  fifo_rd_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ren_ni  (ren_ni),
    .rdata_i (mem_rdata_i),
    .fire_o  (fire),
    .q_o     (q_reg)
  );

  fifo_rd_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (fire),
    .ptr_o  (ptr)
  );

  fifo_rd_mask #(.DATA_W(DATA_W)) u_mask (
    .mode_i (width_mode_e'(mode_i)),
    .oe_ni  (oe_ni),
    .q_i    (q_reg),
    .q_o    (q_o),
    .oe_o   (oe_o)
  );

  assign mem_req_o  = fire;
  assign mem_addr_o = ptr;
  assign ptr_o      = ptr;
endmodule

// File: rtl/fifo_rd_port_chk.sv
module fifo_rd_port_chk #(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ren_ni,
  input logic              oe_ni,
  input logic [1:0]        mode_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] q_o,
  input logic [DATA_W-1:0] oe_o,
  input logic [ADDR_W-1:0] ptr_o,
  input logic [DATA_W-1:0] q_reg
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  a_r1_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |=> (ptr_o == '0 && q_reg == '0 && !mem_req_o));

  a_r2_req_follows_ren: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren_ni |=> (mem_req_o && mem_addr_o == ptr_o));

  a_r5_ptr_advance_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren_ni |-> ##2 (ptr_o == (($past(ptr_o) == LAST) ? '0 : $past(ptr_o) + 1'b1)));

  a_r4_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ren_ni |-> ##2 $stable(ptr_o));

  a_r4_q_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ren_ni |-> ##3 $stable(q_reg));

  a_r6_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (oe_o == '0));

  a_r8_mode10_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01) |-> (oe_o[1:0] == 2'b00 && q_o[1:0] == 2'b00));

  a_r9_mode8_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |-> (oe_o[3:0] == 4'h0 && q_o[3:0] == 4'h0));

  a_r7_full_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && !oe_ni) |-> ($countones(oe_o) == DATA_W && q_o == q_reg));
endmodule

bind fifo_rd_port fifo_rd_port_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ren_ni     (ren_ni),
  .oe_ni      (oe_ni),
  .mode_i     (mode_i),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .q_o        (q_o),
  .oe_o       (oe_o),
  .ptr_o      (ptr_o),
  .q_reg      (q_reg)
);

// File: tb/fifo_rd_port_tb_top.sv
`timescale 1ns/1ps
module fifo_rd_port_tb_top;
  localparam int unsigned DEPTH  = 12;
  localparam int unsigned DATA_W = 12;
  localparam int unsigned ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ren_ni = 1'b1;
  logic              oe_ni = 1'b0;
  logic [1:0]        mode = 2'b00;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic [DATA_W-1:0] q;
  logic [DATA_W-1:0] oe;
  logic [ADDR_W-1:0] ptr;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    checking = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  fifo_rd_port #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ren_ni(ren_ni), .oe_ni(oe_ni), .mode_i(mode),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .q_o(q), .oe_o(oe), .ptr_o(ptr)
  );

  function automatic logic [DATA_W-1:0] word_at(logic [ADDR_W-1:0] a);
    return DATA_W'((32'(a) * 331 + 32'h5a3) ^ (32'(a) << 7));
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(logic [1:0] m);
    case (m)
      2'b00:   return 12'hfff;
      2'b01:   return 12'hffc;
      default: return 12'hff0;
    endcase
  endfunction

  // memory: one-cycle read latency
  always @(posedge clk) if (mem_req) mem_rdata <= word_at(mem_addr);

  // reference model built from the requirements
  logic              m_fire = 1'b0, m_fetch = 1'b0;
  logic [ADDR_W-1:0] m_ptr = '0, m_faddr = '0;
  logic [DATA_W-1:0] m_q = '0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_fire <= 1'b0; m_fetch <= 1'b0; m_ptr <= '0; m_q <= '0;
    end else begin
      m_fire  <= ~ren_ni;
      m_fetch <= m_fire;
      m_faddr <= m_ptr;
      if (m_fire)  m_ptr <= (m_ptr == ADDR_W'(DEPTH - 1)) ? '0 : m_ptr + 1'b1;
      if (m_fetch) m_q <= word_at(m_faddr);
    end
  end

  task automatic check(string t, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !done) begin
      check(tag, "ptr_o", DATA_W'(ptr), DATA_W'(m_ptr));
      check(tag, "q_o", q, m_q & width_mask(mode));
      check(tag, "oe_o", oe, oe_ni ? '0 : width_mask(mode));
    end
  end

  task automatic step(logic r, logic o, logic [1:0] m);
    @(posedge clk);
    #1;
    ren_ni = r; oe_ni = o; mode = m;
  endtask

  task automatic rnd(int n, int ren_pct, logic o_rand, logic [1:0] m);
    for (int i = 0; i < n; i++)
      step(($urandom % 100) >= ren_pct, o_rand ? 1'($urandom) : 1'b0, m);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1b7c_42e5));
    // R1: reset with read enable active
    tag = "R1"; rst_ni = 0; ren_ni = 0;
    step(0, 0, 2'b00);
    checking = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 0, 2'b00);
    // R3: continuous reads, alignment of fetched words
    tag = "R3"; rst_ni = 1;
    for (int i = 0; i < 10; i++) step(0, 0, 2'b00);
    // R5: wrap at a depth that is not a power of two
    tag = "R5";
    for (int i = 0; i < 20; i++) step(0, 0, 2'b00);
    // R4: skip holds pointer and register
    tag = "R4";
    for (int i = 0; i < 6; i++) step(1, 0, 2'b00);
    // R2: isolated single-cycle read pulses
    tag = "R2";
    for (int i = 0; i < 12; i++) step(i[0], 0, 2'b00);
    // R6: outputs disabled
    tag = "R6"; rnd(12, 50, 1'b0, 2'b00);
    for (int i = 0; i < 8; i++) step(i[1], 1, 2'b00);
    // R10: output enable toggling does not disturb reads
    tag = "R10"; rnd(30, 60, 1'b1, 2'b00);
    // R8: 10-bit mode
    tag = "R8"; rnd(20, 50, 1'b1, 2'b01);
    // R9: 8-bit mode, both encodings
    tag = "R9"; rnd(15, 50, 1'b1, 2'b10); rnd(15, 50, 1'b1, 2'b11);
    // R11: return to 12-bit mode with the register held
    tag = "R11";
    step(1, 0, 2'b10); step(1, 0, 2'b10); step(1, 0, 2'b10);
    for (int i = 0; i < 4; i++) step(1, 0, 2'b00);
    // R7: random traffic in 12-bit mode
    tag = "R7"; rnd(200, 50, 1'b0, 2'b00);
    // R1: mid-stream reset with reads requested
    tag = "R1"; rst_ni = 0;
    for (int i = 0; i < 3; i++) step(0, 0, 2'b00);
    rst_ni = 1;
    // R2: long mixed random run
    tag = "R2";
    for (int i = 0; i < 1500; i++)
      step(($urandom % 100) < 55, ($urandom % 8) == 0, 2'($urandom));
    step(1, 0, 2'b00);
    finish_run();
  end
endmodule